// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This block sits between the remainder stage of a binary BCH decoder and the error-locator solver. The remainder stage leaves one 16-bit partial value for each odd syndrome of a sector. The unit turns these values into the full set of 2t syndromes over GF(2^13). The field is generated by x^13 + x^4 + x^3 + x + 1, and exponents wrap modulo 8191.

A one-cycle start pulse captures two inputs: the packed partial words and a capability code that selects t. The unit first evaluates each odd syndrome bit-serially with Horner's rule, so one field multiplier replaces the usual antilog table. It then fills every even syndrome by squaring the syndrome at half its index. A one-cycle done pulse marks the cycle in which the whole array is valid. The array then holds its value until the next accepted start.

Top module: `synx_expand`

## Requirements
- R1: While reset is held and right after it, busy_o and done_o are low and every syndrome on synd_o is zero.
- R2: tsel_i is sampled with start_i and selects t: code 0 gives 2, code 1 gives 4, code 2 gives 8, code 3 gives 12, code 4 gives 24, and codes 5 to 7 also give 24.
- R3: part_i is sampled with start_i. Partial i (i from 0 to t-1) is taken from 32-bit word i/2, where word w occupies part_i[32w+31:32w]. An even i uses bits 15:0 of that word and an odd i uses bits 31:16. Only bits 12:0 of each partial are used, and bits 15:13 have no effect.
- R4: Partial i feeds S(2i+1). S(n) for odd n is the XOR of alpha^((n*j) mod 8191) over every bit j (0..12) that is set in its partial, with alpha = 0x0002.
- R5: For k from 1 to t, S(2k) equals S(k) squared in the field, and it is zero whenever S(k) is zero.
- R6: Every syndrome with index above 2t reads zero after a run, even when an earlier run used a larger t.
- R7: busy_o rises on the clock edge that samples start_i. done_o is a single-cycle pulse raised by the 14t-th rising edge after that one, and busy_o falls on the same edge. synd_o then stays constant until the next accepted start.
- R8: A start_i pulse while busy_o is high is ignored. The running job finishes with its own t, its own data and its own latency.
- R9: synd_o carries S(n) for n = 1 to 48 in bits [13n-1 : 13n-13], so S(1) sits in bits 12:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to expand a new sector |
| tsel_i | input | 3 | Correction capability code, sampled with start_i |
| part_i | input | 384 | Twelve packed 32-bit words of partial values, sampled with start_i |
| busy_o | output | 1 | High while an expansion is running |
| done_o | output | 1 | One-cycle pulse when all syndromes are valid |
| synd_o | output | 624 | Syndromes S(1)..S(48), 13 bits each |

## Verification
Two functions of the unit can fall in the same cycle: a new start request and an ongoing odd-syndrome Horner step. The bench provokes this by raising start_i with a different code and different data five cycles into a run. It judges the outcome by comparing every syndrome, and the time until done, against the model of the first request alone. Back-to-back runs of t=24 followed by t=2 show that the upper syndromes are cleared when the start is accepted. A shrinking t therefore leaves no stale values.

// File: rtl/synx_pkg.sv
// Package for the syndrome expansion unit.
// Holds the controller state type and the mapping from capability code to t.
package synx_pkg;

    typedef enum logic [1:0] {
        SX_IDLE,
        SX_ODD,
        SX_EVEN
    } sx_state_e;

    // Map a 3-bit capability code to a correction count; unknown codes give the maximum.
    function automatic logic [4:0] tcap_of(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd2;
            3'd1:    return 5'd4;
            3'd2:    return 5'd8;
            3'd3:    return 5'd12;
            default: return 5'd24;
        endcase
    endfunction

endpackage

// File: rtl/synx_gf_mul.sv
// Combinational GF(2^M) multiplier.
// Works MSB-first, shifting and reducing by the low terms of the field polynomial.
// Assumes: M >= 3 and POLY_LO holds the polynomial without its x^M term.
module synx_gf_mul #(
    parameter int          M       = 13,
    parameter logic [M-1:0] POLY_LO = 13'h001B
) (
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    output logic [M-1:0] p_o
);

    // Shift-and-add product with reduction at each step.
    always_comb begin
        logic [M-1:0] r;
        r = '0;
        for (int i = M - 1; i >= 0; i--) begin
            r = {r[M-2:0], 1'b0} ^ (r[M-1] ? POLY_LO : '0);
            if (b_i[i]) begin
                r = r ^ a_i;
            end
        end
        p_o = r;
    end

endmodule

// File: rtl/synx_odd_eval.sv
// Bit-serial Horner evaluator: computes sum of bits_i[j] * beta^j.
// The high bit goes in first and one bit is taken per run cycle, so M cycles give one result.
// value_o is valid in the cycle where last_o is high; the accumulator then rewinds.
// Assumes: bits_i and beta_i are held constant across one evaluation.
module synx_odd_eval #(
    parameter int          M       = 13,
    parameter logic [M-1:0] POLY_LO = 13'h001B
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         run_i,
    input  logic [M-1:0] beta_i,
    input  logic [M-1:0] bits_i,
    output logic [M-1:0] value_o,
    output logic         last_o
);

    localparam int BW = $clog2(M);
    localparam logic [BW-1:0] TOP_BIT = BW'(M - 1);

    logic [M-1:0]  acc_q;
    logic [BW-1:0] bitpos_q;
    logic [M-1:0]  prod_w;

    synx_gf_mul #(.M(M), .POLY_LO(POLY_LO)) u_mul (
        .a_i (acc_q),
        .b_i (beta_i),
        .p_o (prod_w)
    );

    // Next Horner value: acc*beta plus the current coefficient bit.
    always_comb begin
        value_o = prod_w ^ {{(M-1){1'b0}}, bits_i[bitpos_q]};
        last_o  = (bitpos_q == '0);
    end

    // Accumulator and bit pointer; both rewind after the lowest bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc_q    <= '0;
            bitpos_q <= TOP_BIT;
        end else if (run_i) begin
            if (last_o) begin
                acc_q    <= '0;
                bitpos_q <= TOP_BIT;
            end else begin
                acc_q    <= value_o;
                bitpos_q <= bitpos_q - 1'b1;
            end
        end
    end

    // R4: an all-zero coefficient set evaluated from zero yields zero.
    a_r4_zero_in_zero_out : assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && acc_q == '0 && bits_i == '0) |-> (value_o == '0));

endmodule

// File: rtl/synx_expand.sv
// Syndrome expansion top.
// When a start is accepted it latches t and the packed partial values and clears the syndrome array.
// It then evaluates S(1), S(3), .. S(2t-1) bit-serially, M cycles each, with a running power of alpha.
// Last, it fills S(2), S(4), .. S(2t) one per cycle by squaring S(k).
// Assumes: T_MAX is even and at least 4, M <= 16.
module synx_expand
    import synx_pkg::*;
#(
    parameter int          M       = 13,
    parameter logic [M-1:0] POLY_LO = 13'h001B,
    parameter int          T_MAX   = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [2:0]                tsel_i,
    input  logic [(T_MAX/2)*32-1:0]   part_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [2*T_MAX*M-1:0]      synd_o
);

    localparam int NSYN   = 2 * T_MAX;
    localparam int NWORDS = T_MAX / 2;
    localparam int IW     = $clog2(T_MAX);
    localparam int KW     = $clog2(T_MAX + 1);
    localparam logic [M-1:0] ALPHA1 = M'(2);
    localparam logic [M-1:0] ALPHA2 = M'(4);

    sx_state_e              st_q;
    logic [KW-1:0]          t_q;
    logic [KW-1:0]          t_req;
    logic [IW-1:0]          idx_q;
    logic [KW-1:0]          k_q;
    logic [M-1:0]           beta_q;
    logic [M-1:0]           beta_nxt;
    logic [NWORDS*32-1:0]   part_q;
    logic [M-1:0]           syn_q [NSYN];
    logic [M-1:0]           bits_w;
    logic [M-1:0]           odd_val;
    logic                   odd_last;
    logic                   accept;
    logic [M-1:0]           sq_src;
    logic [M-1:0]           sq_w;
    logic [M-1:0]           sq_res;

    // Requested t, clamped to what the array can hold.
    always_comb begin
        if (int'(tcap_of(tsel_i)) > T_MAX) begin
            t_req = KW'(T_MAX);
        end else begin
            t_req = KW'(tcap_of(tsel_i));
        end
    end

    assign accept = start_i && (st_q == SX_IDLE);
    assign busy_o = (st_q != SX_IDLE);

    // Partial value for the current odd index: word idx/2, half chosen by idx[0].
    assign bits_w = part_q[int'(idx_q >> 1) * 32 + int'(idx_q[0]) * 16 +: M];

    synx_odd_eval #(.M(M), .POLY_LO(POLY_LO)) u_odd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .run_i   (st_q == SX_ODD),
        .beta_i  (beta_q),
        .bits_i  (bits_w),
        .value_o (odd_val),
        .last_o  (odd_last)
    );

    // Running evaluation point: alpha^(2i+1) advances by alpha^2.
    synx_gf_mul #(.M(M), .POLY_LO(POLY_LO)) u_step (
        .a_i (beta_q),
        .b_i (ALPHA2),
        .p_o (beta_nxt)
    );

    // Source of the square: S(k), guarded against k = 0 while idle.
    always_comb begin
        if (k_q == '0) begin
            sq_src = syn_q[0];
        end else begin
            sq_src = syn_q[int'(k_q) - 1];
        end
    end

    synx_gf_mul #(.M(M), .POLY_LO(POLY_LO)) u_sq (
        .a_i (sq_src),
        .b_i (sq_src),
        .p_o (sq_w)
    );

    // Zero syndrome squares to zero without using the multiplier result.
    assign sq_res = (sq_src == '0) ? '0 : sq_w;

    // Controller: accepts a job, then runs the odd phase and the even phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SX_IDLE;
            t_q    <= KW'(2);
            idx_q  <= '0;
            k_q    <= '0;
            beta_q <= ALPHA1;
            part_q <= '0;
            done_o <= 1'b0;
            for (int n = 0; n < NSYN; n++) begin
                syn_q[n] <= '0;
            end
        end else begin
            done_o <= 1'b0;
            case (st_q)
                SX_IDLE: begin
                    if (start_i) begin
                        t_q    <= t_req;
                        part_q <= part_i;
                        idx_q  <= '0;
                        k_q    <= '0;
                        beta_q <= ALPHA1;
                        for (int n = 0; n < NSYN; n++) begin
                            syn_q[n] <= '0;
                        end
                        st_q <= SX_ODD;
                    end
                end
                SX_ODD: begin
                    if (odd_last) begin
                        syn_q[2 * int'(idx_q)] <= odd_val;
                        beta_q <= beta_nxt;
                        if (int'(idx_q) == int'(t_q) - 1) begin
                            k_q  <= KW'(1);
                            st_q <= SX_EVEN;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                SX_EVEN: begin
                    syn_q[2 * int'(k_q) - 1] <= sq_res;
                    if (k_q == t_q) begin
                        done_o <= 1'b1;
                        st_q   <= SX_IDLE;
                    end else begin
                        k_q <= k_q + 1'b1;
                    end
                end
                default: st_q <= SX_IDLE;
            endcase
        end
    end

    // Flatten the array: S(n) occupies bits [n*M-1 : (n-1)*M].
    for (genvar g = 0; g < NSYN; g++) begin : g_pack
        assign synd_o[g*M +: M] = syn_q[g];
    end

    // ---------------- checking logic ----------------
    logic          hi_nz;
    logic          ev_q;
    logic [KW-1:0] ck_q;
    logic          ck_dst_zero;
    logic          ck_src_zero;

    // Any nonzero syndrome above index 2t.
    always_comb begin
        hi_nz = 1'b0;
        for (int n = 0; n < NSYN; n++) begin
            if (n >= 2 * int'(t_q) && syn_q[n] != '0) begin
                hi_nz = 1'b1;
            end
        end
    end

    // Remember which even slot was written last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= 1'b0;
            ck_q <= KW'(1);
        end else begin
            ev_q <= (st_q == SX_EVEN);
            ck_q <= (k_q == '0) ? KW'(1) : k_q;
        end
    end

    // Zero status of the square just written and of its source.
    always_comb begin
        ck_dst_zero = (syn_q[2 * int'(ck_q) - 1] == '0);
        ck_src_zero = (syn_q[int'(ck_q) - 1] == '0);
    end

    a_r7_done_single : assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_idle : assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r8_start_ignored : assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(t_q) && $stable(part_q)));

    a_r6_upper_clear : assert property (@(posedge clk) disable iff (!rst_n)
        !hi_nz);

    a_r5_square_zero : assert property (@(posedge clk) disable iff (!rst_n)
        ev_q |-> (ck_dst_zero == ck_src_zero));

    a_r2_t_legal : assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (t_q >= KW'(2) && int'(t_q) <= T_MAX && t_q[0] == 1'b0));

endmodule

// File: tb/synx_expand_tb.sv
// Bench: directed corners plus seeded random runs, compared with a bench field model.
module synx_expand_tb;

    localparam int CLK_PERIOD = 10;
    localparam int M      = 13;
    localparam int T_MAX  = 24;
    localparam int NSYN   = 2 * T_MAX;
    localparam int NWORDS = T_MAX / 2;
    localparam int PW     = NWORDS * 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [2:0]        tsel = 3'd0;
    logic [PW-1:0]     part = '0;
    logic              busy;
    logic              done;
    logic [NSYN*M-1:0] synd;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_s [NSYN];

    synx_expand u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .tsel_i  (tsel),
        .part_i  (part),
        .busy_o  (busy),
        .done_o  (done),
        .synd_o  (synd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int get_s(input int n);
        return int'(synd[(n-1)*M +: M]);
    endfunction

    // Carry-less product reduced by x^13+x^4+x^3+x+1 from the top down.
    function automatic int bmul(input int a, input int b);
        logic [25:0] p;
        p = '0;
        for (int i = 0; i < 13; i++) begin
            if (b[i]) p = p ^ (26'(a[12:0]) << i);
        end
        for (int bit_i = 25; bit_i >= 13; bit_i--) begin
            if (p[bit_i]) p = p ^ (26'h201B << (bit_i - 13));
        end
        return int'(p[12:0]);
    endfunction

    function automatic int bpow(input int e);
        int r;
        int base;
        int x;
        r = 1;
        base = 2;
        x = e;
        while (x != 0) begin
            if (x[0]) r = bmul(r, base);
            base = bmul(base, base);
            x = x >> 1;
        end
        return r;
    endfunction

    function automatic int tcap(input logic [2:0] code);
        case (code)
            3'd0: return 2;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 12;
            default: return 24;
        endcase
    endfunction

    function automatic logic [PW-1:0] rand_words();
        logic [PW-1:0] w;
        for (int i = 0; i < NWORDS; i++) w[i*32 +: 32] = $urandom;
        return w;
    endfunction

    // Expected syndromes per the requirements.
    task automatic model(input logic [PW-1:0] w, input int t);
        for (int n = 0; n < NSYN; n++) exp_s[n] = 0;
        for (int i = 0; i < t; i++) begin
            logic [15:0] pv;
            int s;
            int n;
            pv = w[(i/2)*32 + (i%2)*16 +: 16];
            n = 2 * i + 1;
            s = 0;
            for (int j = 0; j < 13; j++) begin
                if (pv[j]) s = s ^ bpow((n * j) % 8191);
            end
            exp_s[n-1] = s;
        end
        for (int k = 1; k <= t; k++) exp_s[2*k-1] = bmul(exp_s[k-1], exp_s[k-1]);
    endtask

    task automatic cmp_all(input int t);
        for (int n = 1; n <= NSYN; n++) begin
            if (n > 2 * t)
                chk(get_s(n) == exp_s[n-1], "R6 upper syndrome zero", get_s(n), exp_s[n-1]);
            else if (n % 2 == 1)
                chk(get_s(n) == exp_s[n-1], "R4 odd syndrome", get_s(n), exp_s[n-1]);
            else
                chk(get_s(n) == exp_s[n-1], "R5 even syndrome", get_s(n), exp_s[n-1]);
        end
    endtask

    task automatic run_case(input logic [2:0] code, input logic [PW-1:0] w, input bit poke);
        int t;
        int cyc;
        bit seen;
        t = tcap(code);
        cyc = 0;
        seen = 1'b0;
        model(w, t);
        @(negedge clk);
        start = 1'b1;
        tsel = code;
        part = w;
        while (!seen && cyc < 2000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (start) begin
                start = 1'b0;
                tsel = 3'($urandom);
                part = rand_words();
            end
            if (cyc == 1) chk(busy == 1'b1, "R7 busy after start", busy, 1);
            if (poke && cyc == 5) begin
                start = 1'b1;
                tsel = (code == 3'd0) ? 3'd4 : 3'd0;
                part = rand_words();
            end
            if (done) seen = 1'b1;
        end
        if (poke)
            chk(seen && cyc == 14 * t + 1, "R8 latency unchanged by ignored start", cyc, 14 * t + 1);
        else
            chk(seen && cyc == 14 * t + 1, "R7 R2 done latency", cyc, 14 * t + 1);
        chk(busy == 1'b0, "R7 busy low at done", busy, 0);
        cmp_all(t);
        @(negedge clk);
        chk(done == 1'b0, "R7 done single cycle", done, 0);
        repeat (3) @(negedge clk);
        chk(get_s(2) == exp_s[1] && get_s(1) == exp_s[0], "R7 output held after done",
            get_s(1), exp_s[0]);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [PW-1:0] w;
        bit allz;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        chk(done == 1'b0, "R1 done in reset", done, 0);
        chk(synd == '0, "R1 syndromes zero in reset", longint'(synd[63:0]), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && synd == '0, "R1 idle after reset", busy, 0);

        // R9 R4: single bit 1 of partial 0 gives S(1) = alpha in bits 12:0
        w = '0;
        w[31:0] = 32'h0000_0002;
        run_case(3'd0, w, 1'b0);
        chk(synd[12:0] == 13'h0002, "R9 S1 field position", synd[12:0], 13'h0002);

        // R3: high half of word 0 is partial 1, feeding S(3)
        w = '0;
        w[31:0] = 32'h0001_0000;
        run_case(3'd0, w, 1'b0);
        chk(get_s(3) == 1 && get_s(1) == 0, "R3 high half feeds S3", get_s(3), 1);

        // R3: bits 15:13 of every partial have no effect
        w = '0;
        for (int i = 0; i < NWORDS; i++) w[i*32 +: 32] = 32'hE000_E000;
        run_case(3'd1, w, 1'b0);
        chk(synd == '0, "R3 bits above 12 ignored", longint'(synd[63:0]), 0);

        // R5: all-zero partials at t=24 give all-zero syndromes
        run_case(3'd4, '0, 1'b0);
        allz = (synd == '0);
        chk(allz, "R5 zero squares to zero", longint'(synd[63:0]), 0);

        // R2: every code, including the ones mapped to 24
        for (int c = 0; c < 8; c++) run_case(3'(c), rand_words(), 1'b0);

        // Random mix
        for (int r = 0; r < 6; r++) run_case(3'($urandom_range(0, 7)), rand_words(), 1'b0);

        // R6: large t followed by small t clears the upper part
        run_case(3'd4, rand_words(), 1'b0);
        run_case(3'd0, rand_words(), 1'b0);
        chk(get_s(5) == 0 && get_s(48) == 0, "R6 stale values cleared", get_s(48), 0);

        // R8: start while busy is ignored
        run_case(3'd2, rand_words(), 1'b1);
        run_case(3'd0, rand_words(), 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule